// File: doc/BRIEF.md
# Indirect Coefficient Access Port

This block gives a host on a byte-wide register bus a way to load and inspect 24-bit filter coefficients that live in an internal RAM. The host first picks an entry with an index register. It then fills three staging bytes (high, middle, low) and writes 1 to an execute bit. The block copies the index and the assembled word into a snapshot and stays busy for a fixed interval. In the last cycle of that interval it writes the snapshot into the RAM once.

The busy interval is given in microseconds and clock megahertz, and is about 100 µs by default. The execute bit reads 1 for the whole interval and clears itself. While the block is busy it ignores writes to the index and staging registers and any second execute request, so a commit cannot be corrupted. For read-back, three read-only byte registers show the RAM word at the current index. They are driven through the block's RAM read port.

Top module: `coef_window`

## Requirements
- R1: After reset, the index, the three staging bytes and the execute/busy bit read 0, and the RAM write enable is low.
- R2: While idle, a write to 0x61 stores the low IDX_W bits of the data as the index, and reading 0x61 returns them zero-extended. Writes to 0x62, 0x63 and 0x64 store bits [23:16], [15:8] and [7:0] of the staged word, and those registers read back what was stored.
- R3: While idle, a write to 0x65 with bit 0 set starts a commit. From the next cycle, bit 0 of 0x65 reads 1 for exactly CLK_MHZ*BUSY_US cycles and then reads 0 without any host action. A write to 0x65 with bit 0 clear does nothing. Bits 7:1 of 0x65 read 0.
- R4: While busy, writes to 0x61 through 0x64 leave those registers unchanged.
- R5: While busy, a write to 0x65 with bit 0 set neither starts a further commit nor lengthens the current one.
- R6: Each commit drives the RAM write enable for exactly one cycle, the last busy cycle. The RAM address and data are the index and word that were staged when the commit was accepted.
- R7: Reading 0x66, 0x67 and 0x68 returns bits [23:16], [15:8] and [7:0] of the RAM entry selected by the current index. Writes to these addresses have no effect.
- R8: Any other address reads 0, and a write to it changes nothing visible.
- R9: Read-back of an entry that is being committed shows the old word up to and including the write cycle, and the new word from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_rdata | output | 8 | Read data for reg_addr |
| ram_we | output | 1 | Coefficient RAM write enable |
| ram_waddr | output | IDX_W | Coefficient RAM write index |
| ram_wdata | output | 24 | Coefficient RAM write word |
| ram_raddr | output | IDX_W | Coefficient RAM read index (the current index) |
| ram_rdata | input | 24 | Coefficient RAM read word, combinational from ram_raddr |

## Verification
Two things can happen in the same cycle. One is the end of a commit, when the RAM write fires and busy drops. The other is a new host write, either an execute request or a staging write. The bench provokes this by issuing execute and staging writes on every cycle of a busy window and on the cycles just after it. The expectation is that a request landing on the final busy cycle is dropped, and that the same request one cycle later is accepted and snapshots the unchanged staging. The bench also reads 0x66 continuously while the committed entry is selected, so the old-to-new change of the read-back word is judged against the exact write cycle.

// File: rtl/coef_win_pkg.sv
package coef_win_pkg;
   localparam int COEF_BYTES = 3;
   localparam int COEF_W     = COEF_BYTES * 8;

   localparam logic [7:0] A_INDEX = 8'h61;
   localparam logic [7:0] A_STG0  = 8'h62;  // first staging byte, most significant
   localparam logic [7:0] A_EXEC  = 8'h65;
   localparam logic [7:0] A_RB0   = 8'h66;  // first read-back byte, most significant

   typedef logic [COEF_W-1:0] coef_t;

   function automatic int lane_lsb(input int lane);
      return (COEF_BYTES - 1 - lane) * 8;
   endfunction
endpackage

// File: rtl/coef_stage.sv
module coef_stage
   import coef_win_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [7:0]       addr,
   input  logic [7:0]       wdata,
   input  logic             lock,
   output logic [IDX_W-1:0] idx,
   output coef_t            word
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         idx <= '0;
      else if (wr && !lock && addr == A_INDEX)
         idx <= wdata[IDX_W-1:0];
   end

   for (genvar g = 0; g < COEF_BYTES; g++) begin : g_lane
      always_ff @(posedge clk) begin
         if (!rst_n)
            word[lane_lsb(g) +: 8] <= '0;
         else if (wr && !lock && addr == A_STG0 + 8'(g))
            word[lane_lsb(g) +: 8] <= wdata;
      end
   end
endmodule

// File: rtl/coef_commit.sv
module coef_commit
   import coef_win_pkg::*;
#(
   parameter int IDX_W       = 6,
   parameter int BUSY_CYCLES = 5000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [IDX_W-1:0] idx,
   input  coef_t            word,
   output logic             busy,
   output logic             we,
   output logic [IDX_W-1:0] waddr,
   output coef_t            wdata
);
   localparam int CNT_W = $clog2(BUSY_CYCLES);

   logic [CNT_W-1:0] remain;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy   <= 1'b0;
         remain <= '0;
         waddr  <= '0;
         wdata  <= '0;
      end else if (busy) begin
         if (remain == '0)
            busy <= 1'b0;
         else
            remain <= remain - 1'b1;
      end else if (start) begin
         busy   <= 1'b1;
         remain <= CNT_W'(BUSY_CYCLES - 1);
         waddr  <= idx;
         wdata  <= word;
      end
   end

   assign we = busy && (remain == '0);
endmodule

// File: rtl/coef_rdmux.sv
module coef_rdmux
   import coef_win_pkg::*;
#(
   parameter int IDX_W = 6
) (
   input  logic [7:0]       addr,
   input  logic [IDX_W-1:0] idx,
   input  coef_t            word,
   input  logic             busy,
   input  coef_t            ram_word,
   output logic [7:0]       rdata
);
   always_comb begin
      rdata = '0;
      if (addr == A_INDEX) rdata = 8'(idx);
      if (addr == A_EXEC)  rdata = {7'b0, busy};
      for (int g = 0; g < COEF_BYTES; g++) begin
         if (addr == A_STG0 + 8'(g)) rdata = word[lane_lsb(g) +: 8];
         if (addr == A_RB0 + 8'(g))  rdata = ram_word[lane_lsb(g) +: 8];
      end
   end
endmodule

// File: rtl/coef_window.sv
module coef_window
   import coef_win_pkg::*;
#(
   parameter int IDX_W    = 6,
   parameter int CLK_MHZ  = 50,
   parameter int BUSY_US  = 100,
   parameter bit READ_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       reg_addr,
   input  logic [7:0]       reg_wdata,
   input  logic             reg_wr,
   output logic [7:0]       reg_rdata,
   output logic             ram_we,
   output logic [IDX_W-1:0] ram_waddr,
   output logic [23:0]      ram_wdata,
   output logic [IDX_W-1:0] ram_raddr,
   input  logic [23:0]      ram_rdata
);
   localparam int BUSY_CYCLES = CLK_MHZ * BUSY_US;

   if (IDX_W < 1 || IDX_W > 8) begin : g_bad_idx
      $error("coef_window: IDX_W must be 1..8");
   end
   if (BUSY_CYCLES < 2) begin : g_bad_busy
      $error("coef_window: busy interval must be at least 2 cycles");
   end

   logic             busy;
   logic [IDX_W-1:0] idx_q;
   coef_t            word_q;
   logic             start;
   logic [7:0]       rd_comb;

   assign start = reg_wr && (reg_addr == A_EXEC) && reg_wdata[0] && !busy;

   coef_stage #(.IDX_W(IDX_W)) u_stage (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .lock(busy), .idx(idx_q), .word(word_q)
   );

   coef_commit #(.IDX_W(IDX_W), .BUSY_CYCLES(BUSY_CYCLES)) u_commit (
      .clk(clk), .rst_n(rst_n), .start(start), .idx(idx_q), .word(word_q),
      .busy(busy), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata)
   );

   coef_rdmux #(.IDX_W(IDX_W)) u_rdmux (
      .addr(reg_addr), .idx(idx_q), .word(word_q), .busy(busy),
      .ram_word(ram_rdata), .rdata(rd_comb)
   );

   assign ram_raddr = idx_q;

   if (READ_REG) begin : g_rd_reg
      logic [7:0] rdata_q;
      always_ff @(posedge clk) begin
         if (!rst_n) rdata_q <= '0;
         else        rdata_q <= rd_comb;
      end
      assign reg_rdata = rdata_q;
   end else begin : g_rd_comb
      assign reg_rdata = rd_comb;
   end
endmodule

// File: rtl/coef_window_chk.sv
module coef_window_chk
   import coef_win_pkg::*;
#(
   parameter int IDX_W       = 6,
   parameter int BUSY_CYCLES = 5000
) (
   input logic             clk,
   input logic             rst_n,
   input logic [7:0]       reg_addr,
   input logic [7:0]       reg_wdata,
   input logic             reg_wr,
   input logic             busy,
   input logic [IDX_W-1:0] idx_q,
   input coef_t            word_q,
   input logic             ram_we,
   input logic [IDX_W-1:0] ram_waddr,
   input coef_t            ram_wdata
);
   int run_cnt;
   always_ff @(posedge clk) begin
      if (!rst_n || !busy) run_cnt <= 0;
      else                 run_cnt <= run_cnt + 1;
   end

   AST_START_ACCEPTED: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == A_EXEC && reg_wdata[0] && !busy) |=> busy); // R3
   AST_WE_INSIDE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> busy); // R6
   AST_WE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |-> (run_cnt == BUSY_CYCLES - 1)); // R6
   AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> !ram_we); // R6
   AST_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we |=> !busy); // R3
   AST_NO_STRETCH: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (run_cnt < BUSY_CYCLES)); // R5
   AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(idx_q) && $stable(word_q))); // R4
   AST_SNAPSHOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> ($stable(ram_waddr) && $stable(ram_wdata))); // R6
endmodule

bind coef_window coef_window_chk #(.IDX_W(IDX_W), .BUSY_CYCLES(BUSY_CYCLES)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .reg_wr(reg_wr), .busy(busy), .idx_q(idx_q), .word_q(word_q),
   .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata)
);

// File: tb/coef_window_test.sv
`timescale 1ns/1ps
module coef_window_test;
   localparam int IDX_W   = 6;
   localparam int BUSY_US = 1;
   localparam int BUSY    = 50 * BUSY_US;
   localparam int DEPTH   = 1 << IDX_W;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [7:0]       reg_addr = '0;
   logic [7:0]       reg_wdata = '0;
   logic             reg_wr = 1'b0;
   logic [7:0]       reg_rdata;
   logic             ram_we;
   logic [IDX_W-1:0] ram_waddr, ram_raddr;
   logic [23:0]      ram_wdata, ram_rdata;

   always #10 clk = ~clk;

   coef_window #(.IDX_W(IDX_W), .CLK_MHZ(50), .BUSY_US(BUSY_US)) uut (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
      .reg_wr(reg_wr), .reg_rdata(reg_rdata), .ram_we(ram_we),
      .ram_waddr(ram_waddr), .ram_wdata(ram_wdata), .ram_raddr(ram_raddr),
      .ram_rdata(ram_rdata)
   );

   // environment RAM
   logic [23:0] mem [DEPTH];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      end else if (ram_we) mem[ram_waddr] <= ram_wdata;
   end
   assign ram_rdata = mem[ram_raddr];

   // behavioural reference model
   int m_idx, m_hi, m_mid, m_lo, m_busy, m_rem, s_idx, s_word;
   int mram [DEPTH];
   int model_commits = 0, dut_we = 0;
   int compared = 0, mismatched = 0;
   bit done = 0;

   always @(posedge clk) begin
      int was;
      if (!rst_n) begin
         m_idx = 0; m_hi = 0; m_mid = 0; m_lo = 0; m_busy = 0; m_rem = 0;
         s_idx = 0; s_word = 0;
         for (int i = 0; i < DEPTH; i++) mram[i] = 0;
      end else begin
         was = m_busy;
         if (m_busy != 0) begin
            if (m_rem == 0) begin
               mram[s_idx] = s_word; m_busy = 0; model_commits++;
            end else m_rem--;
         end else if (reg_wr && reg_addr == 8'h65 && reg_wdata[0]) begin
            m_busy = 1; m_rem = BUSY - 1; s_idx = m_idx;
            s_word = (m_hi << 16) | (m_mid << 8) | m_lo;
         end
         if (was == 0 && reg_wr) begin
            case (reg_addr)
               8'h61: m_idx = int'(reg_wdata) % DEPTH;
               8'h62: m_hi  = int'(reg_wdata);
               8'h63: m_mid = int'(reg_wdata);
               8'h64: m_lo  = int'(reg_wdata);
               default: ;
            endcase
         end
      end
   end

   function automatic int exp_rd(input logic [7:0] a);
      case (a)
         8'h61: return m_idx;
         8'h62: return m_hi;
         8'h63: return m_mid;
         8'h64: return m_lo;
         8'h65: return m_busy;
         8'h66: return (mram[m_idx] >> 16) & 255;
         8'h67: return (mram[m_idx] >> 8) & 255;
         8'h68: return mram[m_idx] & 255;
         default: return 0;
      endcase
   endfunction

   function automatic string tag_of(input logic [7:0] a);
      if (a >= 8'h61 && a <= 8'h64) return "R2/R4";
      if (a == 8'h65) return "R3/R5";
      if (a >= 8'h66 && a <= 8'h68) return "R7/R9";
      return "R8";
   endfunction

   task automatic check(input string tag, input int act, input int exp);
      compared++;
      if (act != exp) begin
         mismatched++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, away from the active edge
   always @(negedge clk) begin
      if (!done) begin
         int ew;
         ew = (m_busy != 0 && m_rem == 0) ? 1 : 0;
         check(tag_of(reg_addr), int'(reg_rdata), exp_rd(reg_addr));
         check("R6 we", int'(ram_we), ew);
         if (ew != 0 && ram_we) begin
            check("R6 waddr", int'(ram_waddr), s_idx);
            check("R6 wdata", int'(ram_wdata), s_word);
         end
         if (ram_we) dut_we++;
      end
   end

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      @(posedge clk); #2;
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
   endtask

   task automatic rd(input logic [7:0] a);
      @(posedge clk); #2;
      reg_addr = a; reg_wr = 1'b0;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < BUSY + 4; k++) rd(8'h65);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (4) @(posedge clk);
      #2 rst_n = 1'b1;
      // R1: reset state
      rd(8'h65); @(negedge clk); check("R1 busy", int'(reg_rdata), 0);
      check("R1 we", int'(ram_we), 0);
      rd(8'h61); @(negedge clk); check("R1 index", int'(reg_rdata), 0);
      rd(8'h62); @(negedge clk); check("R1 stage", int'(reg_rdata), 0);
      // R2: staging while idle
      wr(8'h61, 8'hC5); wr(8'h62, 8'h3D); wr(8'h63, 8'hED); wr(8'h64, 8'hE7);
      rd(8'h61); rd(8'h62); rd(8'h63); rd(8'h64);
      // R3: execute with bit 0 clear does nothing
      wr(8'h65, 8'hFE); rd(8'h65); rd(8'h65);
      // R3/R4/R5/R9: commit, then hammer the window during busy and around its end
      wr(8'h65, 8'h01);
      for (int k = 0; k < BUSY + 6; k++) begin
         case (k % 4)
            0: wr(8'h61, 8'(k));
            1: wr(8'h62, 8'(k * 7));
            2: wr(8'h65, 8'h01);
            default: rd(8'h66);
         endcase
      end
      wait_idle();
      rd(8'h66); rd(8'h67); rd(8'h68);
      // R7/R8: writes to read-only and unmapped addresses
      wr(8'h66, 8'hAA); wr(8'h5F, 8'h11); wr(8'h70, 8'h22); rd(8'h70); rd(8'h66);
      // back-to-back execute right after completion
      wr(8'h65, 8'h01);
      for (int k = 0; k < BUSY + 3; k++) wr(8'h65, 8'h01);
      wait_idle();
      // random traffic
      for (int k = 0; k < 600; k++) begin
         logic [7:0] a;
         a = 8'h5F + 8'($urandom_range(0, 11));
         if ($urandom_range(0, 2) != 0) wr(a, 8'($urandom));
         else rd(a);
      end
      wait_idle();
      // sweep read-back of every entry
      for (int i = 0; i < DEPTH; i++) begin
         wr(8'h61, 8'(i)); rd(8'h66); rd(8'h67); rd(8'h68);
      end
      rd(8'h65);
      @(negedge clk);
      check("R5 commit count", dut_we, model_commits);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule